// File: doc/BRIEF.md
# Zero-Turnaround Synchronous Burst SRAM Model

This block is a synthesizable model of a 32-bit synchronous burst SRAM in pipelined mode. Reads and writes may follow each other on consecutive clock edges with no idle cycle between them. On every enabled rising edge the block decodes three chip-select inputs, a load/advance strobe and a read/write select. A burst is either started at an external address or continued from an internal 2-bit burst counter. The counter steps through a four-word group in either linear or interleaved order. Four active-low byte-write strobes pick which 8-bit lanes of a write are stored. A stall input freezes the whole block for as long as it is held.

Read data comes out on a registered data-out bus. A separate valid flag stands in for the drivers of a tri-state bus, and that flag also depends on an active-low output enable. Write data is taken two enabled edges after its command. That is the same slot in which a read issued at the same point would return its data, so the shared bus never has to change direction with a gap. If a write is followed at once by a read of the same word, the read returns the freshly written lanes.

Top module: `zt_sram`

## Requirements
- R1: The device is selected when en0_n=0, en1=1 and en2_n=0. A load cycle (adv=0) with any other combination is a deselect: no array location changes, and the slot it would have used shows dout_vld=0.
- R2: A continue cycle (adv=1) after a deselect, or after reset before any burst was started, performs no operation. dout_vld stays 0 in its slot and no location changes.
- R3: For a read command sampled at enabled edge k, dout carries the word, and dout_vld is 1 while oe_n=0. This holds from just after enabled edge k+1 until enabled edge k+2. Reads and writes may be issued on back-to-back edges.
- R4: For a write command sampled at enabled edge k, din is sampled at enabled edge k+2. A read of the same address issued at edge k+1 returns the new data.
- R5: bw_n[i]=0 stores din[8i+7:8i] into its lane of the addressed word. Lanes with bw_n[i]=1 keep their old contents. bw_n is sampled with each command, both begin and continue cycles.
- R6: A write with bw_n=4'b1111 is an abort: the addressed word is unchanged and dout_vld stays 0 in its slot.
- R7: Whether a burst reads or writes is fixed by rd_wr in its load cycle. Continue cycles ignore rd_wr and the three chip selects.
- R8: Beat c (0 to 3) of a burst starting at address B keeps B's upper bits. Its low two bits are (B[1:0]+c) mod 4 when lin_mode=1 at load, and B[1:0] XOR c when lin_mode=0. After the fourth beat the counter wraps to the start address.
- R9: dout_vld is 1 only for a read slot with oe_n=0. Write slots never drive, even with oe_n=0. A read with oe_n=1 is a dummy read, and its continue cycles still advance the burst address.
- R10: While stall=1 at an edge, no state changes and no write occurs. dout holds its value, dout_vld keeps its read/not-read state, and all other inputs at that edge are ignored.
- R11: After a synchronous reset (rst_n=0) no burst is active and dout_vld is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| stall | input | 1 | Clock-inhibit: 1 freezes the block for that edge |
| en0_n | input | 1 | Chip select, active low |
| en1 | input | 1 | Chip select, active high |
| en2_n | input | 1 | Chip select, active low |
| adv | input | 1 | 0 = load a new address, 1 = continue the burst |
| rd_wr | input | 1 | 1 = read, 0 = write; sampled in load cycles |
| bw_n | input | LANES | Active-low byte-lane write strobes |
| lin_mode | input | 1 | Burst order at load: 1 = linear, 0 = interleaved |
| oe_n | input | 1 | Output enable, active low, combinational on dout_vld |
| addr | input | AW | Word address, sampled in load cycles |
| din | input | LANES*LW | Write data, sampled two enabled edges after its command |
| dout | output | LANES*LW | Registered read data |
| dout_vld | output | 1 | Stands in for the bus being driven |

## Verification
The array is filled with write bursts and read back in the opposite burst order, using start offsets at all four positions in a group. A wrong step in either order then places data at the wrong word, and a single-beat read sweep separates order faults from data faults. Write and read bursts, and single write/read pairs on the same word, are alternated with no idle edge. This exposes pipeline slot errors and any missing same-address bypass. All sixteen byte-strobe patterns, aborts, the eight chip-select combinations, continues after deselect, dummy reads with mixed output enable, and type-flipping continue cycles are each followed by read-backs. Stalls with conflicting inputs are inserted between beats to show that they neither advance the burst nor commit data.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stall,
  input  logic                en0_n,
  input  logic                en1,
  input  logic                en2_n,
  input  logic                adv,
  input  logic                rd_wr,
  input  logic [LANES-1:0]    bw_n,
  input  logic                lin_mode,
  input  logic                oe_n,
  input  logic [AW-1:0]       addr,
  input  logic [LANES*LW-1:0] din,
  output logic [LANES*LW-1:0] dout,
  output logic                dout_vld
);
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic          sel, go, load;
  logic          b_act, b_rd, b_lin;
  logic [AW-1:0] b_base;
  logic [1:0]    b_cnt;

  logic          c_v, c_rd, c_lin;
  logic [AW-1:0] c_base, c_addr;
  logic [1:0]    c_cnt, c_low;

  logic             s1_v, s1_rd, s2_v, s2_rd;
  logic [AW-1:0]    s1_addr, s2_addr;
  logic [LANES-1:0] s1_bw, s2_bw;

  logic          wr_go, hit, rd_live;
  logic [DW-1:0] fwd, dout_q;

  assign sel  = !en0_n && en1 && !en2_n;
  assign go   = !stall;
  assign load = !adv;

  assign c_v    = load ? sel : b_act;
  assign c_rd   = load ? rd_wr : b_rd;
  assign c_lin  = load ? lin_mode : b_lin;
  assign c_base = load ? addr : b_base;
  assign c_cnt  = load ? 2'd0 : b_cnt + 2'd1;
  assign c_low  = c_lin ? c_base[1:0] + c_cnt : c_base[1:0] ^ c_cnt;
  assign c_addr = {c_base[AW-1:2], c_low};

  assign wr_go = go && rst_n && s2_v && !s2_rd;
  assign hit   = wr_go && (s2_addr == s1_addr);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign fwd[i*LW +: LW] = (hit && !s2_bw[i]) ? din[i*LW +: LW]
                                                : mem[s1_addr][i*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_act   <= 1'b0;
      b_rd    <= 1'b0;
      b_lin   <= 1'b0;
      b_base  <= '0;
      b_cnt   <= 2'd0;
      s1_v    <= 1'b0;
      s1_rd   <= 1'b0;
      s1_addr <= '0;
      s1_bw   <= '1;
      s2_v    <= 1'b0;
      s2_rd   <= 1'b0;
      s2_addr <= '0;
      s2_bw   <= '1;
      rd_live <= 1'b0;
      dout_q  <= '0;
    end else if (go) begin
      b_act   <= c_v;
      b_rd    <= c_rd;
      b_lin   <= c_lin;
      b_base  <= c_base;
      b_cnt   <= c_cnt;
      s1_v    <= c_v;
      s1_rd   <= c_rd;
      s1_addr <= c_addr;
      s1_bw   <= bw_n;
      s2_v    <= s1_v;
      s2_rd   <= s1_rd;
      s2_addr <= s1_addr;
      s2_bw   <= s1_bw;
      rd_live <= s1_v && s1_rd;
      if (s1_v && s1_rd) dout_q <= fwd;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) begin
      for (int i = 0; i < LANES; i++) begin
        if (!s2_bw[i]) mem[s2_addr][i*LW +: LW] <= din[i*LW +: LW];
      end
    end
  end

  assign dout     = dout_q;
  assign dout_vld = rd_live && !oe_n;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic          adv,
  input logic          sel,
  input logic [DW-1:0] dout,
  input logic          dout_vld,
  input logic          b_act,
  input logic [1:0]    b_cnt,
  input logic          s1_v,
  input logic          s1_rd,
  input logic          rd_live
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(dout) && $stable(b_cnt) && $stable(b_act) && $stable(rd_live));

  p_wr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && s1_v && !s1_rd) |=> !dout_vld);

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && adv && b_act) |=> (b_cnt == $past(b_cnt) + 2'd1));

  p_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !adv && !sel) |=> (!b_act && !s1_v));

  p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !adv && sel) |=> (b_act && s1_v && b_cnt == 2'd0));

  p_cont_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && adv && !b_act) |=> !s1_v);
endmodule

bind zt_sram zt_sram_chk #(.DW(LANES*LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .adv(adv), .sel(sel),
  .dout(dout), .dout_vld(dout_vld), .b_act(b_act), .b_cnt(b_cnt),
  .s1_v(s1_v), .s1_rd(s1_rd), .rd_live(rd_live)
);

// File: tb/sim_zt_sram.sv
module sim_zt_sram;
  localparam int TCK = 10;
  localparam int AW  = 8;

  logic clk = 1'b0, rst_n = 1'b0, stall = 1'b0;
  logic en0_n = 1'b1, en1 = 1'b0, en2_n = 1'b0;
  logic adv = 1'b0, rd_wr = 1'b1, lin_mode = 1'b0, oe_n = 1'b0;
  logic [3:0]    bw_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [31:0]   din = '0;
  logic [31:0]   dout;
  logic          dout_vld;

  zt_sram u0 (
    .clk(clk), .rst_n(rst_n), .stall(stall), .en0_n(en0_n), .en1(en1),
    .en2_n(en2_n), .adv(adv), .rd_wr(rd_wr), .bw_n(bw_n),
    .lin_mode(lin_mode), .oe_n(oe_n), .addr(addr), .din(din),
    .dout(dout), .dout_vld(dout_vld)
  );

  always #(TCK/2) clk = ~clk;

  int total = 0, bad = 0, wseq = 0;
  string tag = "R11";
  logic [31:0] refm [1 << AW];

  int          p1_k = 0, p2_k = 0;
  logic [AW-1:0] p1_a = '0, p2_a = '0;
  logic [3:0]  p1_bw = 4'hF, p2_bw = 4'hF;
  logic        cur_oe = 1'b0;
  logic        m_act = 1'b0, m_rd = 1'b0, m_lin = 1'b0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]  m_cnt = 2'd0;

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wdat(input logic [AW-1:0] a, input int s);
    return (32'h9E37_79B9 * (32'(a) + 32'd1)) ^ (32'(s) * 32'h0101_0F0F);
  endfunction

  task automatic cyc(input logic st, input logic ad, input logic [2:0] ce,
                     input logic rw, input logic [3:0] bw, input logic [AW-1:0] a,
                     input logic ln, input logic oe);
    int nk;
    logic [AW-1:0] na;
    logic [1:0] lo;
    @(negedge clk);
    if (p2_k == 1) begin
      chk({31'b0, dout_vld}, {31'b0, !cur_oe});
      if (!cur_oe) chk(dout, refm[p2_a]);
    end else begin
      chk({31'b0, dout_vld}, 32'd0);
    end
    stall = st; adv = ad; {en0_n, en1, en2_n} = ce; rd_wr = rw;
    bw_n = bw; addr = a; lin_mode = ln; oe_n = oe; cur_oe = oe;
    if (st) begin
      din = 32'hDEAD_BEEF ^ 32'(wseq * 7);
    end else begin
      if (p2_k == 2) begin
        din = wdat(p2_a, wseq);
        wseq++;
        for (int l = 0; l < 4; l++)
          if (!p2_bw[l]) refm[p2_a][l*8 +: 8] = din[l*8 +: 8];
      end else begin
        din = 32'h0BAD_F00D ^ 32'(wseq);
      end
      nk = 0; na = '0;
      if (!ad) begin
        if (ce == 3'b010) begin
          m_act = 1'b1; m_rd = rw; m_base = a; m_cnt = 2'd0; m_lin = ln;
          nk = rw ? 1 : 2; na = a;
        end else begin
          m_act = 1'b0;
        end
      end else if (m_act) begin
        m_cnt = m_cnt + 2'd1;
        lo = m_lin ? m_base[1:0] + m_cnt : m_base[1:0] ^ m_cnt;
        nk = m_rd ? 1 : 2;
        na = {m_base[AW-1:2], lo};
      end
      p2_k = p1_k; p2_a = p1_a; p2_bw = p1_bw;
      p1_k = nk;   p1_a = na;   p1_bw = bw;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 3'b100, 1, 4'hF, '0, 0, 0);
  endtask
  task automatic wr1(input logic [AW-1:0] a, input logic [3:0] bw);
    cyc(0, 0, 3'b010, 0, bw, a, 0, 0);
  endtask
  task automatic rd1(input logic [AW-1:0] a);
    cyc(0, 0, 3'b010, 1, 4'h0, a, 0, 0);
  endtask
  task automatic hold(input int s);
    cyc(1, 1'(s), 3'b010, 1'(s >> 1), 4'(s), AW'(s * 13), 1'(s >> 2), 1'(s >> 3));
  endtask
  task automatic wburst(input logic [AW-1:0] b, input logic ln, input logic [3:0] bw);
    cyc(0, 0, 3'b010, 0, bw, b, ln, 0);
    for (int i = 0; i < 3; i++) cyc(0, 1, 3'b010, 0, bw, '0, 0, 0);
  endtask
  task automatic rburst(input logic [AW-1:0] b, input logic ln, input logic oe);
    cyc(0, 0, 3'b010, 1, 4'h0, b, ln, oe);
    for (int i = 0; i < 3; i++) cyc(0, 1, 3'b010, 1, 4'h0, '0, 0, oe);
  endtask

  initial begin
    #(TCK * 150000);
    bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) refm[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R11";
    chk({31'b0, dout_vld}, 32'd0);
    rst_n = 1'b1;
    idle(3);

    tag = "R2";
    for (int i = 0; i < 3; i++) cyc(0, 1, 3'b010, 1, 4'h0, '0, 0, 0);
    idle(1);
    for (int i = 0; i < 4; i++) cyc(0, 1, 3'b010, i[0], 4'h0, AW'(i), 0, 0);
    idle(2);

    tag = "R8";
    for (int g = 0; g < 16; g++) wburst(AW'(g * 4 + g % 4), g[0], 4'h0);
    for (int g = 0; g < 16; g++) rburst(AW'(g * 4 + (g + 1) % 4), !g[0], 0);
    for (int a = 0; a < 64; a++) rd1(AW'(a));
    cyc(0, 0, 3'b010, 1, 4'h0, 8'd6, 1, 0);
    for (int i = 0; i < 7; i++) cyc(0, 1, 3'b010, 1, 4'h0, '0, 0, 0);
    cyc(0, 0, 3'b010, 1, 4'h0, 8'd7, 0, 0);
    for (int i = 0; i < 7; i++) cyc(0, 1, 3'b010, 1, 4'h0, '0, 0, 0);

    tag = "R3";
    for (int g = 0; g < 8; g++) begin
      wburst(AW'(64 + g * 4 + g % 4), g[1], 4'h0);
      rburst(AW'(64 + g * 4 + (g + 2) % 4), !g[1], 0);
    end

    tag = "R4";
    for (int i = 0; i < 16; i++) begin
      wr1(AW'(100 + i), 4'h0);
      rd1(AW'(100 + i));
    end
    for (int i = 0; i < 8; i++) begin
      wr1(AW'(116 + i), 4'h0);
      rd1(AW'(115 + i));
      rd1(AW'(116 + i));
    end

    tag = "R5";
    for (int i = 0; i < 16; i++) begin
      wr1(AW'(128 + i), 4'h0);
      wr1(AW'(128 + i), 4'(i));
      rd1(AW'(128 + i));
    end
    for (int i = 0; i < 16; i++) rd1(AW'(128 + i));

    tag = "R6";
    for (int i = 0; i < 8; i++) begin
      wr1(AW'(i), 4'hF);
      rd1(AW'(i));
    end
    wburst(8'd32, 1, 4'hF);
    rburst(8'd32, 0, 0);

    tag = "R9";
    rburst(8'd40, 0, 1);
    cyc(0, 0, 3'b010, 1, 4'h0, 8'd41, 1, 1);
    for (int i = 0; i < 3; i++) cyc(0, 1, 3'b010, 1, 4'h0, '0, 0, 0);
    wburst(8'd48, 0, 4'h0);
    rburst(8'd48, 1, 0);

    tag = "R7";
    cyc(0, 0, 3'b010, 1, 4'h0, 8'd20, 1, 0);
    for (int i = 0; i < 3; i++) cyc(0, 1, 3'b100, 0, 4'h0, AW'(i), 0, 0);
    cyc(0, 0, 3'b010, 0, 4'h0, 8'd201, 1, 0);
    for (int i = 0; i < 3; i++) cyc(0, 1, 3'b111, 1, 4'h0, AW'(i), 0, 0);
    rburst(8'd200, 0, 0);
    rburst(8'd20, 0, 0);

    tag = "R1";
    for (int c = 0; c < 8; c++) cyc(0, 0, 3'(c), 1, 4'hF, 8'd5, 0, 0);
    for (int c = 0; c < 8; c++) begin
      cyc(0, 0, 3'(c), 0, 4'h0, 8'd6, 0, 0);
      rd1(8'd6);
    end

    tag = "R10";
    for (int g = 0; g < 6; g++) begin
      cyc(0, 0, 3'b010, 0, 4'h0, AW'(160 + g * 4 + g % 4), g[0], 0);
      for (int h = 0; h < g % 3 + 1; h++) hold(g * 5 + h);
      for (int i = 0; i < 3; i++) begin
        cyc(0, 1, 3'b010, 0, 4'h0, '0, 0, 0);
        for (int h = 0; h < (g + i) % 3; h++) hold(g + i + h * 3);
      end
      cyc(0, 0, 3'b010, 1, 4'h0, AW'(160 + g * 4), !g[0], 0);
      for (int h = 0; h < 3; h++) hold(h * 9 + g);
      for (int i = 0; i < 3; i++) begin
        cyc(0, 1, 3'b010, 1, 4'h0, '0, 0, 0);
        hold(i + g * 2);
      end
    end
    for (int i = 0; i < 24; i++) rd1(AW'(160 + i));

    tag = "R3";
    idle(4);
    summary();
    $finish;
  end
endmodule